// File: doc/BRIEF.md
# Programmable-Priority Vectored Interrupt Controller

The controller watches sixteen pending interrupt lines. Fourteen of them (lines 0 to 13) each carry a software-programmed 4-bit priority level. Among the pending lines that the mask lets through, it picks the one with the highest level. It then forms a vector address from that winner's level, not from its line number. The level is multiplied by a coded vector spacing. The product is added to a fixed interrupt offset of 0x200 and then to an exception base supplied at the port.

Software reaches four 32-bit registers through a simple port. Writes are synchronous and reads are combinational. The registers are a status view of the pending lines, a control register, and two packed level registers. The low eight mask bits come from an input. The upper eight mask bits, a timer enable and the spacing code sit in the control register. The winner, its level, a valid flag and the vector are recomputed combinationally every cycle from the registered state.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, all registers read as zero, irq_valid is 0, irq_level is 0, timer_en is 0, and irq_vector equals exc_base + 0x200.
- R2: The level registers are at address 2 (lines 0..7) and address 3 (lines 8..13). Line i occupies bits 4*(i mod 8)+3 : 4*(i mod 8) of its register. Bits 31:24 of address 3 read as zero.
- R3: The control register is at address 1. Bits 15:8 hold the upper mask for lines 15..8, bit 7 holds the timer enable (driven on timer_en), and bits 4:0 hold the spacing code. Bits 31:16 and 6:5 read as zero.
- R4: The status register is at address 0. Bits 23:8 show irq_pend as registered on the previous clock edge. Bit 24 is the vector-enable flag, which only a status write changes (from wdata bit 24). Bit 31 shows bd_in as registered on the previous edge. All other bits read as zero.
- R5: Line i is active when its registered pending bit is 1 and its mask bit is 1. Mask bits 7:0 come from mask_lo and bits 15:8 from the control register.
- R6: The winner is the active line among 0..13 with the numerically highest level. Ties go to the lowest line index. Lines 14 and 15 never win.
- R7: irq_valid is 1 exactly when some line among 0..13 is active. irq_id and irq_level give the winner's index and level. Both are 0 when irq_valid is 0.
- R8: The spacing codes 0x00, 0x01, 0x02, 0x04, 0x08 and 0x10 select spacings of 0x000, 0x020, 0x040, 0x080, 0x100 and 0x200. Every other code selects spacing 0x000.
- R9: irq_vector = exc_base + 0x200 + irq_level*spacing while the vector-enable flag is 1. While the flag is 0, irq_vector = exc_base + 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | 16 | Raw pending interrupt lines |
| mask_lo | input | 8 | Mask bits for lines 7..0 |
| bd_in | input | 1 | Branch-delay flag shown in status |
| exc_base | input | 32 | Exception base address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| timer_en | output | 1 | Timer enable from control bit 7 |
| irq_valid | output | 1 | An active prioritized line exists |
| irq_id | output | 4 | Winning line index |
| irq_level | output | 4 | Winning line's level |
| irq_vector | output | 32 | Vector address |

## Verification
The bench builds the block with its default parameters: fourteen prioritized lines, 4-bit levels and a 0x200 fixed offset. With these values the whole space of level by spacing code fits in a direct sweep. Every one of the 16 levels is crossed with all 32 spacing codes, reserved codes included, on a single line. Randomized rounds over all level registers, pending lines and both halves of the mask then reach the ties, the masking of the upper lines, and the non-winning lines 14 and 15.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NUM_PEND = 16,
  parameter int NUM_VEC  = 14,
  parameter int LVL_W    = 4,
  parameter int AW       = 32,
  parameter logic [31:0] BASE_OFS = 32'h200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PEND-1:0] irq_pend,
  input  logic [7:0]          mask_lo,
  input  logic                bd_in,
  input  logic [AW-1:0]       exc_base,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                timer_en,
  output logic                irq_valid,
  output logic [3:0]          irq_id,
  output logic [LVL_W-1:0]    irq_level,
  output logic [AW-1:0]       irq_vector
);
  localparam int HI_BITS = (NUM_VEC - 8) * LVL_W;

  logic [NUM_PEND-1:0] pend_q;
  logic                iv_q, bd_q, te_q;
  logic [7:0]          im_q;
  logic [4:0]          sp_q;
  logic [31:0]         lvl_lo_q;
  logic [HI_BITS-1:0]  lvl_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      iv_q     <= 1'b0;
      bd_q     <= 1'b0;
      te_q     <= 1'b0;
      im_q     <= '0;
      sp_q     <= '0;
      lvl_lo_q <= '0;
      lvl_hi_q <= '0;
    end else begin
      pend_q <= irq_pend;
      bd_q   <= bd_in;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: iv_q <= reg_wdata[24];
          2'd1: begin
            im_q <= reg_wdata[15:8];
            te_q <= reg_wdata[7];
            sp_q <= reg_wdata[4:0];
          end
          2'd2: lvl_lo_q <= reg_wdata;
          default: lvl_hi_q <= reg_wdata[HI_BITS-1:0];
        endcase
      end
    end
  end

  wire [NUM_VEC*LVL_W-1:0] lvl_all = {lvl_hi_q, lvl_lo_q};
  wire [NUM_PEND-1:0]      act     = pend_q & {im_q, mask_lo};

  always_comb begin
    irq_valid = 1'b0;
    irq_id    = '0;
    irq_level = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (act[i] && (!irq_valid || lvl_all[i*LVL_W +: LVL_W] > irq_level)) begin
        irq_valid = 1'b1;
        irq_id    = 4'(i);
        irq_level = lvl_all[i*LVL_W +: LVL_W];
      end
    end
  end

  logic [AW-1:0] spacing;
  always_comb begin
    case (sp_q)
      5'h01:   spacing = AW'(32'h020);
      5'h02:   spacing = AW'(32'h040);
      5'h04:   spacing = AW'(32'h080);
      5'h08:   spacing = AW'(32'h100);
      5'h10:   spacing = AW'(32'h200);
      default: spacing = '0;
    endcase
  end

  wire [AW-1:0] vec_ofs = iv_q ? AW'(irq_level) * spacing : '0;
  assign irq_vector = exc_base + AW'(BASE_OFS) + vec_ofs;
  assign timer_en   = te_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {bd_q, 6'b0, iv_q, pend_q, 8'b0};
      2'd1:    reg_rdata = {16'b0, im_q, te_q, 2'b0, sp_q};
      2'd2:    reg_rdata = lvl_lo_q;
      default: reg_rdata = {{(32-HI_BITS){1'b0}}, lvl_hi_q};
    endcase
  end
endmodule

// File: rtl/prio_vec_intc_checker.sv
module prio_vec_intc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] irq_pend,
  input logic [15:0] pend_q,
  input logic [7:0]  im_q,
  input logic [7:0]  mask_lo,
  input logic [31:0] exc_base,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        irq_valid,
  input logic [3:0]  irq_id,
  input logic [3:0]  irq_level,
  input logic [31:0] irq_vector
);
  wire [15:0] act  = pend_q & {im_q, mask_lo};
  wire [31:0] vofs = irq_vector - exc_base;

  AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> act[irq_id]); // R5
  AST_NO_HI_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_id < 4'd14)); // R6
  AST_IDLE_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_level == 4'd0 && irq_vector == exc_base + 32'h200)); // R7
  AST_VALID_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (act[13:0] != 14'd0) |-> irq_valid); // R7
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vofs >= 32'h200 && vofs <= 32'h2000)); // R9
  AST_CTL_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[31:16] == 16'd0 && reg_rdata[6:5] == 2'd0)); // R3
  AST_HI_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata[31:24] == 8'd0)); // R2
  AST_PEND_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && reg_addr == 2'd0) |-> (reg_rdata[23:8] == $past(irq_pend))); // R4
endmodule

bind prio_vec_intc prio_vec_intc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .pend_q(pend_q), .im_q(im_q),
  .mask_lo(mask_lo), .exc_base(exc_base), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .irq_valid(irq_valid), .irq_id(irq_id), .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_pend = '0;
  logic [7:0]  mask_lo = '0;
  logic        bd_in = 1'b0;
  logic [31:0] exc_base = 32'h8000_0000;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        timer_en, irq_valid;
  logic [3:0]  irq_id, irq_level;
  logic [31:0] irq_vector;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_lo, m_hi, m_ctl;
  logic        m_iv;

  always #4 clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .mask_lo(mask_lo), .bd_in(bd_in),
    .exc_base(exc_base), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .timer_en(timer_en), .irq_valid(irq_valid), .irq_id(irq_id),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      2'd0: m_iv = d[24];
      2'd1: m_ctl = d & 32'h0000_FF9F;
      2'd2: m_lo = d;
      default: m_hi = d & 32'h00FF_FFFF;
    endcase
  endtask

  task automatic rdchk(string req, logic [1:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  function automatic logic [31:0] spc(logic [4:0] c);
    case (c)
      5'h01: return 32'h20;
      5'h02: return 32'h40;
      5'h04: return 32'h80;
      5'h08: return 32'h100;
      5'h10: return 32'h200;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_outs(string req);
    logic [15:0] a;
    logic        v;
    logic [3:0]  id, lv, l;
    a = irq_pend & {m_ctl[15:8], mask_lo};
    v = 1'b0; id = 0; lv = 0;
    for (int i = 0; i < 14; i++) begin
      l = (i < 8) ? 4'((m_lo >> (4*i)) & 32'hF) : 4'((m_hi >> (4*(i-8))) & 32'hF);
      if (a[i] && (!v || l > lv)) begin
        v = 1'b1; id = 4'(i); lv = l;
      end
    end
    chk({req, " valid R7"}, 32'(irq_valid), 32'(v));
    chk({req, " id R6"}, 32'(irq_id), 32'(id));
    chk({req, " level R6"}, 32'(irq_level), 32'(lv));
    chk({req, " vector R9"}, irq_vector,
        exc_base + 32'h200 + (m_iv ? 32'(lv) * spc(m_ctl[4:0]) : 32'h0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_lo = 0; m_hi = 0; m_ctl = 0; m_iv = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) rdchk("R1 reset reg", 2'(a), 32'h0);
    chk("R1 valid", 32'(irq_valid), 0);
    chk("R1 level", 32'(irq_level), 0);
    chk("R1 timer_en", 32'(timer_en), 0);
    chk("R1 vector", irq_vector, 32'h8000_0200);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 register layout
    wr(2'd2, 32'hFFFF_FFFF); rdchk("R2 lo all ones", 2'd2, 32'hFFFF_FFFF);
    wr(2'd2, 32'h7654_3210); rdchk("R2 lo pattern", 2'd2, 32'h7654_3210);
    wr(2'd3, 32'hFFFF_FFFF); rdchk("R2 hi masked", 2'd3, 32'h00FF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF); rdchk("R3 ctl masked", 2'd1, 32'h0000_FF9F);
    chk("R3 timer_en on", 32'(timer_en), 1);
    wr(2'd1, 32'h0000_0100); chk("R3 timer_en off", 32'(timer_en), 0);
    rdchk("R3 ctl readback", 2'd1, 32'h0000_0100);
    wr(2'd0, 32'hFFFF_FFFF); rdchk("R4 status iv only", 2'd0, 32'h0100_0000);
    rdchk("R4 status write no effect on ctl", 2'd1, 32'h0000_0100);
    irq_pend = 16'hA5C3; bd_in = 1'b1;
    @(negedge clk);
    rdchk("R4 status pend bd", 2'd0, 32'h81A5_C300);
    irq_pend = 16'h0000; bd_in = 1'b0;
    @(negedge clk);
    rdchk("R4 status cleared", 2'd0, 32'h0100_0000);

    // R8 R9 sweep: line 5 at every level with every code
    mask_lo = 8'hFF;
    wr(2'd2, 32'h0);
    irq_pend = 16'h0020;
    for (int lv = 0; lv < 16; lv++) begin
      wr(2'd2, 32'(lv) << 20);
      for (int c = 0; c < 32; c++) begin
        wr(2'd1, 32'(c));
        chk("R8 sweep vector", irq_vector, 32'h8000_0200 + 32'(lv) * spc(5'(c)));
        chk("R7 sweep valid", 32'(irq_valid), 1);
      end
    end

    // R9 vector enable cleared
    wr(2'd1, 32'h10);
    wr(2'd0, 32'h0);
    check_outs("R9 iv off");
    wr(2'd0, 32'h0100_0000);

    // R6 lines 14/15 never win, R5 upper mask
    wr(2'd1, 32'hFF10);
    irq_pend = 16'hC000;
    @(negedge clk);
    chk("R6 hi lines no win", 32'(irq_valid), 0);
    irq_pend = 16'h2000;
    @(negedge clk);
    check_outs("R5 upper mask on");
    wr(2'd1, 32'hDF10);
    check_outs("R5 upper mask off");
    chk("R5 line13 masked", 32'(irq_valid), 0);

    // R6 tie goes to lowest index
    wr(2'd2, 32'h3303_3000);
    wr(2'd1, 32'hFF04);
    irq_pend = 16'h00FF;
    @(negedge clk);
    chk("R6 tie id", 32'(irq_id), 3);

    // random arbitration rounds
    for (int n = 0; n < 400; n++) begin
      wr(2'd2, $urandom);
      wr(2'd3, $urandom);
      wr(2'd1, $urandom);
      if (n % 7 == 0) wr(2'd0, 32'(n % 2) << 24);
      mask_lo = 8'($urandom);
      irq_pend = 16'($urandom);
      exc_base = $urandom;
      @(negedge clk);
      check_outs("R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule